// File: doc/BRIEF.md
# PCM Highway Slot and Bit Timer

This block derives the bit and time-slot timing of a serial PCM highway. It runs in the system clock domain and sees the PCM data clock only as two one-cycle enables, one for each data clock edge. A frame sync input is sampled on a chosen data clock edge. A rising sync edge restarts the frame. Between sync edges the counters free-run over a programmable number of 8-bit slots per frame, from 4 to 128. The data clock can run at the bit rate or at twice the bit rate.

The block keeps two position counters of its own, one for transmit and one for receive. Each counter can place its frame start a programmable number of bit periods after the sync point. For each direction the block gives a slot index, a bit index, a strobe for every new bit, and a one-cycle frame-start pulse. The data path that moves bytes uses these to know which bit of which slot is on the wire.

Top module: `pcm_slot_timer`

## Requirements
- R1: While reset is held and on the first cycles after it, all slot indices, bit indices, strobes and frame-start pulses are 0.
- R2: A sync edge is a sample where fsync is 1 and the previous sample was 0. On the cycle after the sample that sees it, both strobes are 1 and each direction's position is realigned. With an offset of 0 the position is slot 0, bit 0, and the frame-start pulse is 1.
- R3: When sync_on_fall is 0, fsync is sampled only in cycles with dclk_rise. When it is 1, fsync is sampled only in cycles with dclk_fall. A level change seen only on the other edge does not realign the counters.
- R4: When double_rate is 0, each dclk_rise with no sync edge advances each direction's position by one bit. The position and strobe (1 for exactly one cycle) appear on the following cycle.
- R5: When double_rate is 1, the position advances on every second dclk_rise counted from the sync edge. The first dclk_rise after the sync leaves the position unchanged and gives no strobe.
- R6: The position is slot*8+bit, with bit 0..7 in the low index. Bit 7 is followed by bit 0 of the next slot. The last slot is followed by slot 0, bit 0 together with a frame-start pulse.
- R7: A slots_cfg value below 4 acts as 4, and a value above 128 acts as 128.
- R8: At a sync edge a direction with offset k (0 < k < frame bits) loads position frame_bits-k. Its frame-start pulse therefore comes k bit periods after the sync. Offsets of frame bits or more act as 0. The transmit and receive offsets act independently.
- R9: Without sync edges the counters keep wrapping frame after frame.
- R10: A sync edge in the middle of a frame realigns both directions at once, as in R2.
- R11: An fsync held at 1 gives only one realignment, however many samples see it.
- R12: A frame-start pulse lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dclk_rise | input | 1 | One-cycle enable for a rising data clock edge |
| dclk_fall | input | 1 | One-cycle enable for a falling data clock edge |
| fsync | input | 1 | Frame sync level |
| slots_cfg | input | 8 | Slots per frame (4..128) |
| double_rate | input | 1 | 1: the data clock runs at twice the bit rate |
| sync_on_fall | input | 1 | 1: sample fsync on falling data clock edges |
| tx_offset | input | 10 | Transmit frame offset in bit periods |
| rx_offset | input | 10 | Receive frame offset in bit periods |
| tx_slot | output | 7 | Transmit slot index |
| tx_bit | output | 3 | Transmit bit index |
| tx_strobe | output | 1 | New transmit bit |
| tx_frame_start | output | 1 | Transmit frame start pulse |
| rx_slot | output | 7 | Receive slot index |
| rx_bit | output | 3 | Receive bit index |
| rx_strobe | output | 1 | New receive bit |
| rx_frame_start | output | 1 | Receive frame start pulse |

## Verification
A wrong position counter shows at the slot and bit outputs on the cycle after the next bit step, because every output is registered from the same state. A wrong divide-by-two phase shows as a strobe on the first rising edge after a sync in double-rate mode. A wrong sync-edge history shows as a realignment while fsync is held high, within one sample. A wrong wrap or offset load shows as a frame-start pulse at a position other than the one computed from the offset. This is seen no later than one frame after the sync.

// File: rtl/pcm_timing_pkg.sv
package pcm_timing_pkg;
    localparam int unsigned PCM_BITS_PER_SLOT = 8;
    localparam int unsigned PCM_BIT_IDX_W     = 3;
    localparam int unsigned PCM_MIN_SLOTS     = 4;

    typedef enum logic {
        RATE_SINGLE = 1'b0,
        RATE_DOUBLE = 1'b1
    } pcm_rate_e;

    typedef enum logic {
        SYNC_ON_RISE = 1'b0,
        SYNC_ON_FALL = 1'b1
    } pcm_sync_edge_e;
endpackage

// File: rtl/pcm_sync_sampler.sv
module pcm_sync_sampler
    import pcm_timing_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic dclk_rise,
    input  logic dclk_fall,
    input  logic sync_on_fall,
    input  logic fsync,
    output logic hit
);
    typedef struct packed {
        logic last;
    } smp_t;

    smp_t smp_d, smp_q;
    logic sample_en;
    pcm_sync_edge_e edge_sel;

    always_comb begin
        edge_sel  = pcm_sync_edge_e'(sync_on_fall);
        sample_en = (edge_sel == SYNC_ON_FALL) ? dclk_fall : dclk_rise;
        smp_d     = smp_q;
        if (sample_en) begin
            smp_d.last = fsync;
        end
        hit = sample_en && fsync && !smp_q.last;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            smp_q <= '0;
        end else begin
            smp_q <= smp_d;
        end
    end

    // R11
    sync_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> !hit);
endmodule

// File: rtl/pcm_bit_pacer.sv
module pcm_bit_pacer
    import pcm_timing_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic dclk_rise,
    input  logic double_rate,
    input  logic hit,
    output logic adv
);
    typedef struct packed {
        logic phase;
    } pace_t;

    pace_t pace_d, pace_q;
    pcm_rate_e rate;

    always_comb begin
        rate   = pcm_rate_e'(double_rate);
        pace_d = pace_q;
        adv    = 1'b0;
        if (hit) begin
            pace_d.phase = 1'b0;
        end else if (dclk_rise) begin
            if (rate == RATE_DOUBLE) begin
                adv          = pace_q.phase;
                pace_d.phase = ~pace_q.phase;
            end else begin
                adv          = 1'b1;
                pace_d.phase = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pace_q <= '0;
        end else begin
            pace_q <= pace_d;
        end
    end

    // R5
    double_pace_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (double_rate && adv) |-> !$past(adv));
endmodule

// File: rtl/pcm_dir_counter.sv
module pcm_dir_counter
    import pcm_timing_pkg::*;
#(
    parameter int unsigned CNT_W = 10,
    localparam int unsigned TOT_W  = CNT_W + 1,
    localparam int unsigned SLOT_W = CNT_W - PCM_BIT_IDX_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     hit,
    input  logic                     adv,
    input  logic [TOT_W-1:0]         frame_bits,
    input  logic [CNT_W-1:0]         offset,
    output logic [SLOT_W-1:0]        slot,
    output logic [PCM_BIT_IDX_W-1:0] bit_idx,
    output logic                     strobe,
    output logic                     frame_start
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             strobe;
        logic             fs;
    } dir_t;

    dir_t dir_d, dir_q;
    logic [TOT_W-1:0] nxt_wide;
    logic [TOT_W-1:0] load_wide;
    logic [CNT_W-1:0] wrapped;
    logic [CNT_W-1:0] load_val;

    always_comb begin
        nxt_wide  = {1'b0, dir_q.cnt} + TOT_W'(1);
        wrapped   = (nxt_wide >= frame_bits) ? '0 : nxt_wide[CNT_W-1:0];
        load_wide = frame_bits - {1'b0, offset};
        if ((offset == '0) || ({1'b0, offset} >= frame_bits)) begin
            load_val = '0;
        end else begin
            load_val = load_wide[CNT_W-1:0];
        end

        dir_d        = dir_q;
        dir_d.strobe = 1'b0;
        dir_d.fs     = 1'b0;
        if (hit) begin
            dir_d.cnt    = load_val;
            dir_d.strobe = 1'b1;
            dir_d.fs     = (load_val == '0);
        end else if (adv) begin
            dir_d.cnt    = wrapped;
            dir_d.strobe = 1'b1;
            dir_d.fs     = (wrapped == '0);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q <= '0;
        end else begin
            dir_q <= dir_d;
        end
    end

    assign slot        = dir_q.cnt[CNT_W-1:PCM_BIT_IDX_W];
    assign bit_idx     = dir_q.cnt[PCM_BIT_IDX_W-1:0];
    assign strobe      = dir_q.strobe;
    assign frame_start = dir_q.fs;

    // R6
    frame_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> (slot == '0 && bit_idx == '0 && strobe));

    // R4
    hold_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe |-> $stable(dir_q.cnt));

    // R12
    fs_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> !frame_start);
endmodule

// File: rtl/pcm_slot_timer.sv
module pcm_slot_timer
    import pcm_timing_pkg::*;
#(
    parameter int unsigned MAX_SLOTS = 128,
    localparam int unsigned CFG_W  = $clog2(MAX_SLOTS + 1),
    localparam int unsigned CNT_W  = $clog2(MAX_SLOTS * PCM_BITS_PER_SLOT),
    localparam int unsigned TOT_W  = CNT_W + 1,
    localparam int unsigned SLOT_W = CNT_W - PCM_BIT_IDX_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     dclk_rise,
    input  logic                     dclk_fall,
    input  logic                     fsync,
    input  logic [CFG_W-1:0]         slots_cfg,
    input  logic                     double_rate,
    input  logic                     sync_on_fall,
    input  logic [CNT_W-1:0]         tx_offset,
    input  logic [CNT_W-1:0]         rx_offset,
    output logic [SLOT_W-1:0]        tx_slot,
    output logic [PCM_BIT_IDX_W-1:0] tx_bit,
    output logic                     tx_strobe,
    output logic                     tx_frame_start,
    output logic [SLOT_W-1:0]        rx_slot,
    output logic [PCM_BIT_IDX_W-1:0] rx_bit,
    output logic                     rx_strobe,
    output logic                     rx_frame_start
);
    localparam int unsigned NUM_DIR = 2;

    logic                     hit;
    logic                     adv;
    logic [CFG_W-1:0]         slots_c;
    logic [TOT_W-1:0]         frame_bits;
    logic [CNT_W-1:0]         off_a   [NUM_DIR];
    logic [SLOT_W-1:0]        slot_a  [NUM_DIR];
    logic [PCM_BIT_IDX_W-1:0] bit_a   [NUM_DIR];
    logic                     strb_a  [NUM_DIR];
    logic                     fs_a    [NUM_DIR];

    always_comb begin
        if (slots_cfg < CFG_W'(PCM_MIN_SLOTS)) begin
            slots_c = CFG_W'(PCM_MIN_SLOTS);
        end else if (slots_cfg > CFG_W'(MAX_SLOTS)) begin
            slots_c = CFG_W'(MAX_SLOTS);
        end else begin
            slots_c = slots_cfg;
        end
        frame_bits = TOT_W'(slots_c) * TOT_W'(PCM_BITS_PER_SLOT);
    end

    assign off_a[0] = tx_offset;
    assign off_a[1] = rx_offset;

    pcm_sync_sampler u_sync (
        .clk         (clk),
        .rst_n       (rst_n),
        .dclk_rise   (dclk_rise),
        .dclk_fall   (dclk_fall),
        .sync_on_fall(sync_on_fall),
        .fsync       (fsync),
        .hit         (hit)
    );

    pcm_bit_pacer u_pace (
        .clk        (clk),
        .rst_n      (rst_n),
        .dclk_rise  (dclk_rise),
        .double_rate(double_rate),
        .hit        (hit),
        .adv        (adv)
    );

    for (genvar g = 0; g < NUM_DIR; g++) begin : g_dir
        pcm_dir_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk        (clk),
            .rst_n      (rst_n),
            .hit        (hit),
            .adv        (adv),
            .frame_bits (frame_bits),
            .offset     (off_a[g]),
            .slot       (slot_a[g]),
            .bit_idx    (bit_a[g]),
            .strobe     (strb_a[g]),
            .frame_start(fs_a[g])
        );
    end

    assign tx_slot        = slot_a[0];
    assign tx_bit         = bit_a[0];
    assign tx_strobe      = strb_a[0];
    assign tx_frame_start = fs_a[0];
    assign rx_slot        = slot_a[1];
    assign rx_bit         = bit_a[1];
    assign rx_strobe      = strb_a[1];
    assign rx_frame_start = fs_a[1];

    // R2
    sync_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> (tx_strobe && rx_strobe));

    // R10
    sync_zero_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && tx_offset == '0) |=> (tx_frame_start && tx_slot == '0 && tx_bit == '0));
endmodule

// File: tb/pcm_slot_timer_tb.sv
module pcm_slot_timer_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       dclk_rise = 1'b0;
    logic       dclk_fall = 1'b0;
    logic       fsync = 1'b0;
    logic [7:0] slots_cfg = 8'd32;
    logic       double_rate = 1'b0;
    logic       sync_on_fall = 1'b0;
    logic [9:0] tx_offset = '0;
    logic [9:0] rx_offset = '0;
    logic [6:0] tx_slot, rx_slot;
    logic [2:0] tx_bit, rx_bit;
    logic       tx_strobe, rx_strobe, tx_frame_start, rx_frame_start;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    pcm_slot_timer u_dut (
        .clk(clk), .rst_n(rst_n), .dclk_rise(dclk_rise), .dclk_fall(dclk_fall),
        .fsync(fsync), .slots_cfg(slots_cfg), .double_rate(double_rate),
        .sync_on_fall(sync_on_fall), .tx_offset(tx_offset), .rx_offset(rx_offset),
        .tx_slot(tx_slot), .tx_bit(tx_bit), .tx_strobe(tx_strobe),
        .tx_frame_start(tx_frame_start), .rx_slot(rx_slot), .rx_bit(rx_bit),
        .rx_strobe(rx_strobe), .rx_frame_start(rx_frame_start)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic chk_tx(input string req, input int pos, input int fs, input int st);
        chk({req, " tx slot"}, int'(tx_slot), pos / 8);
        chk({req, " tx bit"}, int'(tx_bit), pos % 8);
        chk({req, " tx frame_start"}, int'(tx_frame_start), fs);
        chk({req, " tx strobe"}, int'(tx_strobe), st);
    endtask

    task automatic chk_rx(input string req, input int pos, input int fs);
        chk({req, " rx slot"}, int'(rx_slot), pos / 8);
        chk({req, " rx bit"}, int'(rx_bit), pos % 8);
        chk({req, " rx frame_start"}, int'(rx_frame_start), fs);
    endtask

    task automatic do_reset(input logic [7:0] slots, input logic dbl, input logic on_fall,
                            input logic [9:0] txo, input logic [9:0] rxo);
        @(negedge clk);
        rst_n = 1'b0;
        fsync = 1'b0;
        slots_cfg = slots;
        double_rate = dbl;
        sync_on_fall = on_fall;
        tx_offset = txo;
        rx_offset = rxo;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic pulse_rise();
        dclk_rise = 1'b1;
        @(negedge clk);
        dclk_rise = 1'b0;
    endtask

    task automatic pulse_fall();
        dclk_fall = 1'b1;
        @(negedge clk);
        dclk_fall = 1'b0;
    endtask

    task automatic steps(input int n);
        for (int i = 0; i < n; i++) begin
            pulse_rise();
            @(negedge clk);
        end
        // pulse_rise leaves the sample cycle; step back one idle to align:
    endtask

    task automatic step_one();
        @(negedge clk);
        pulse_rise();
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk_tx("R1 in reset", 0, 0, 0);
        chk_rx("R1 in reset", 0, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk_tx("R1 after reset", 0, 0, 0);
        chk_rx("R1 after reset", 0, 0);
    endtask

    task automatic t_single();
        do_reset(8'd32, 1'b0, 1'b0, 10'd0, 10'd5);
        fsync = 1'b1;
        pulse_rise();
        chk_tx("R2 sync", 0, 1, 1);
        chk_rx("R8 rx offset load", 251, 0);
        chk("R2 rx strobe", int'(rx_strobe), 1);
        @(negedge clk);
        chk("R12 tx fs one cycle", int'(tx_frame_start), 0);
        chk("R4 strobe one cycle", int'(tx_strobe), 0);
        for (int i = 1; i <= 5; i++) step_one();
        chk_tx("R4 five bits", 5, 0, 1);
        chk_rx("R8 rx frame start", 0, 1);
        for (int i = 6; i <= 8; i++) step_one();
        chk_tx("R6 bit wrap into slot 1", 8, 0, 1);
        chk_rx("R11 held fsync no realign", 3, 0);
        for (int i = 9; i <= 256; i++) step_one();
        chk_tx("R6 R9 frame wrap", 0, 1, 1);
        chk_rx("R9 rx free run", 251, 0);
        for (int i = 1; i <= 10; i++) step_one();
        fsync = 1'b0;
        step_one();
        chk_tx("R9 before mid sync", 11, 0, 1);
        @(negedge clk);
        fsync = 1'b1;
        pulse_rise();
        chk_tx("R10 mid-frame realign", 0, 1, 1);
        chk_rx("R10 rx realign", 251, 0);
    endtask

    task automatic t_edge_sel();
        do_reset(8'd32, 1'b0, 1'b1, 10'd0, 10'd0);
        pulse_fall();
        for (int i = 1; i <= 3; i++) step_one();
        chk_tx("R3 pre-run", 3, 0, 1);
        @(negedge clk);
        fsync = 1'b1;
        pulse_rise();
        chk_tx("R3 rise ignored for sync", 4, 0, 1);
        @(negedge clk);
        pulse_fall();
        chk_tx("R3 fall sample realigns", 0, 1, 1);
        chk_rx("R3 rx realign", 0, 1);
    endtask

    task automatic t_double();
        do_reset(8'd4, 1'b1, 1'b0, 10'd0, 10'd0);
        fsync = 1'b1;
        pulse_rise();
        chk_tx("R5 sync", 0, 1, 1);
        step_one();
        chk_tx("R5 first rise holds", 0, 0, 0);
        step_one();
        chk_tx("R5 second rise advances", 1, 0, 1);
        step_one();
        step_one();
        chk_tx("R5 fourth rise", 2, 0, 1);
    endtask

    task automatic t_clamp();
        do_reset(8'd2, 1'b0, 1'b0, 10'd0, 10'd3);
        fsync = 1'b1;
        pulse_rise();
        chk_rx("R7 R8 small frame rx load", 29, 0);
        for (int i = 1; i <= 31; i++) step_one();
        chk_tx("R7 min frame last bit", 31, 0, 1);
        step_one();
        chk_tx("R7 min frame wrap", 0, 1, 1);
        do_reset(8'd200, 1'b0, 1'b0, 10'd0, 10'd1);
        fsync = 1'b1;
        pulse_rise();
        chk_rx("R7 R8 max frame rx load", 1023, 0);
        for (int i = 1; i <= 1023; i++) step_one();
        chk_tx("R7 max frame last bit", 1023, 0, 1);
        chk_rx("R8 rx start after one bit", 1022, 0);
        step_one();
        chk_tx("R7 max frame wrap", 0, 1, 1);
        chk_rx("R8 rx independent", 1023, 0);
    endtask

    initial begin
        t_reset();
        t_single();
        t_edge_sel();
        t_double();
        t_clamp();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule